// File: doc/BRIEF.md
# Idle Request Acknowledge Agent

This block is the peripheral side of a clock-gating handshake. A power manager raises `idle_req` when it wants to stop the peripheral's clocks. The agent decides when to answer with `idle_ack`. Software cannot start the handshake. It can only choose the acknowledge policy, through a 2-bit mode field, and choose which interrupt sources may wake the system.

There are four policies:
- **Force:** answers at once, whatever the peripheral is doing.
- **Never:** keeps the clocks running by not answering at all.
- **Activity-gated:** waits until no bus transaction and no interrupt request is pending.
- **Activity-gated with wake-up:** answers the same way as activity-gated. Once idled, it also raises `wake_req` when an enabled interrupt source fires.

Both outputs are registered. Both stay asserted until the power manager withdraws its request.

Top module: `idle_ack_agent`

## Requirements
- R1: After reset the mode is 00, the wake enables are 0, and `idle_ack` and `wake_req` are low.
- R2: In mode 00, `idle_ack` rises on the clock after one where `idle_req` is high, whatever the activity inputs are.
- R3: In mode 01, `idle_ack` never rises.
- R4: In modes 10 and 11, `idle_ack` rises only on the clock after a cycle in which `idle_req` is high, `bus_busy` is low and `irq_pend` is all zero. While any activity is present, acknowledge is held off.
- R5: Once `idle_ack` is high, it stays high while `idle_req` stays high, even if activity returns or the mode is rewritten.
- R6: One clock after `idle_req` is sampled low, both `idle_ack` and `wake_req` are low.
- R7: In mode 11, `wake_req` rises on the clock after a cycle in which `idle_ack`, `irq_evt[i]` and wake enable i are all high. It then stays high until `idle_req` is withdrawn.
- R8: `wake_req` is never raised in modes 00, 01 or 10. In mode 11, an event on a source whose wake-enable bit is 0 raises no wake-up.
- R9: A write with `cfg_sel`=0 loads the mode from `cfg_wdata[4:3]`. A write with `cfg_sel`=1 loads wake enable i from `cfg_wdata[i]`. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = config (mode at bits 4:3), 1 = wake enables |
| cfg_wdata | input | 5 | Write data |
| idle_req | input | 1 | Idle request from the power manager |
| bus_busy | input | 1 | A bus transaction is pending |
| irq_pend | input | NIRQ | Per-source interrupt request pending |
| irq_evt | input | NIRQ | Per-source interrupt event pulse |
| idle_ack | output | 1 | Idle acknowledge to the power manager |
| wake_req | output | 1 | Wake-up request while idled |

## Verification
The assertions assume that `idle_req` is a clean synchronous level and that the activity inputs are valid on every clock. They do not assume any particular relation between `idle_req` and activity. Only the mode history seen since reset is relied on.

The stimulus draws `idle_req` as long random bursts, so that requests are held long enough to be acknowledged and then withdrawn. Activity and interrupt events are drawn with biased probabilities, so that both quiet windows and busy windows occur. Register writes, including mode changes while a request is pending, are mixed in at random. Directed cases cover the reset state and the masked wake-enable case.

// File: rtl/idle_ack_agent.sv
module idle_ack_agent #(
  parameter int NIRQ = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [4:0]      cfg_wdata,
  input  logic            idle_req,
  input  logic            bus_busy,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_evt,
  output logic            idle_ack,
  output logic            wake_req
);

  localparam logic [1:0] M_FORCE = 2'b00;
  localparam logic [1:0] M_NEVER = 2'b01;
  localparam logic [1:0] M_WAKE  = 2'b11;

  logic [1:0]      mode;
  logic [NIRQ-1:0] wake_en;
  logic            quiet, grant, wake_hit;
  logic            unused_bit;

  assign unused_bit = cfg_wdata[2];
  assign quiet      = !bus_busy && (irq_pend == '0);
  assign grant      = (mode == M_FORCE) || (mode[1] && quiet);
  assign wake_hit   = idle_ack && |(irq_evt & wake_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_FORCE;
      wake_en <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) wake_en <= cfg_wdata[NIRQ-1:0];
      else         mode    <= cfg_wdata[4:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ack <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      idle_ack <= idle_req && (idle_ack || grant);
      wake_req <= idle_req && (mode == M_WAKE) && (wake_req || wake_hit);
    end
  end

  a_r2_force_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && mode == M_FORCE) |=> idle_ack);
  a_r3_never_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NEVER && !idle_ack) |=> !idle_ack);
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !idle_ack && (bus_busy || irq_pend != '0)) |=> !idle_ack);
  a_r5_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ack && idle_req) |=> idle_ack);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> (!idle_ack && !wake_req));
  a_r7_wake_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> idle_ack);
  a_r8_wake_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(mode) == M_WAKE);

endmodule

// File: tb/tb_idle_ack_agent.sv
module tb_idle_ack_agent;
  localparam int NIRQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, idle_req = 1'b0, bus_busy = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [NIRQ-1:0] irq_pend = '0, irq_evt = '0;
  logic idle_ack, wake_req;

  idle_ack_agent #(.NIRQ(NIRQ)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .idle_req(idle_req), .bus_busy(bus_busy),
    .irq_pend(irq_pend), .irq_evt(irq_evt), .idle_ack(idle_ack),
    .wake_req(wake_req));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [1:0] m_mode = 2'b00;
  logic [NIRQ-1:0] m_en = '0;
  logic m_ack = 0, m_wake = 0;
  string ack_tag = "R1", wake_tag = "R1";

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  function automatic logic next_ack(logic req, logic busy, logic [NIRQ-1:0] pend);
    return req && (m_ack || m_mode == 2'b00 || (m_mode[1] && !busy && pend == '0));
  endfunction

  function automatic logic next_wake(logic req, logic [NIRQ-1:0] evt);
    return req && m_mode == 2'b11 && (m_wake || (m_ack && |(evt & m_en)));
  endfunction

  task automatic step(input logic req, input logic busy, input logic [NIRQ-1:0] pend,
                      input logic [NIRQ-1:0] evt, input logic we, input logic sel,
                      input logic [4:0] data);
    @(negedge clk);
    check(idle_ack, m_ack, ack_tag, "idle_ack");
    check(wake_req, m_wake, wake_tag, "wake_req");
    idle_req = req; bus_busy = busy; irq_pend = pend; irq_evt = evt;
    cfg_we = we; cfg_sel = sel; cfg_wdata = data;
    if (!req) ack_tag = "R6";
    else if (m_ack) ack_tag = "R5";
    else if (m_mode == 2'b00) ack_tag = "R2";
    else if (m_mode == 2'b01) ack_tag = "R3";
    else ack_tag = "R4";
    if (!req) wake_tag = "R6";
    else if (m_mode == 2'b11) wake_tag = "R7";
    else wake_tag = "R8";
    begin
      logic na, nw;
      na = next_ack(req, busy, pend);
      nw = next_wake(req, evt);
      m_ack = na; m_wake = nw;
    end
    if (we) begin
      if (sel) m_en = data[NIRQ-1:0];
      else     m_mode = data[4:3];
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(idle_ack, 1'b0, "R1", "idle_ack after reset");
    check(wake_req, 1'b0, "R1", "wake_req after reset");
    rst_n = 1'b1;
    // R1: default mode 00 acknowledges even while busy
    step(1, 1, 2'b11, 2'b00, 0, 0, 5'd0);
    step(1, 1, 2'b11, 2'b11, 0, 0, 5'd0);
    check(idle_ack, 1'b1, "R1", "default mode acks");
    check(wake_req, 1'b0, "R1", "default wake enables");
    step(0, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    // R9: select mode 11 (bits 4:3), wake enable bit 0 only
    step(0, 0, 2'b00, 2'b00, 1, 0, 5'b11000);
    step(0, 0, 2'b00, 2'b00, 1, 1, 5'b00001);
    step(1, 1, 2'b00, 2'b00, 0, 0, 5'd0);
    step(1, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    step(1, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    check(idle_ack, 1'b1, "R9", "mode 11 acks when quiet");
    // R8: event on disabled source 1 gives no wake
    step(1, 0, 2'b00, 2'b10, 0, 0, 5'd0);
    step(1, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    check(wake_req, 1'b0, "R8", "masked source no wake");
    // R7: enabled source 0 wakes and holds
    step(1, 0, 2'b00, 2'b01, 0, 0, 5'd0);
    step(1, 1, 2'b01, 2'b00, 0, 0, 5'd0);
    step(1, 1, 2'b01, 2'b00, 0, 0, 5'd0);
    check(wake_req, 1'b1, "R7", "wake held");
    step(0, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    step(0, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    check(idle_ack, 1'b0, "R6", "ack released");
    check(wake_req, 1'b0, "R6", "wake released");
    r = 0;
    for (int i = 0; i < 4000; i++) begin
      logic we;
      if ($urandom_range(0, 19) == 0) r = ~r;
      we = ($urandom_range(0, 24) == 0);
      step(r, $urandom_range(0, 9) < 3, ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00,
           ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00,
           we, 1'($urandom), 5'($urandom));
    end
    step(0, 0, 2'b00, 2'b00, 0, 0, 5'd0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule